// File: doc/BRIEF.md
# Receive Frame Buffer with Descriptor Ring

This block sits between a receive MAC and a host. Incoming frames arrive as a byte stream and are packed, little-endian, into a circular byte store. Each frame is published through a ring of receive descriptors. The upstream side first looks at `can_accept_o`, which goes high only when a descriptor slot and enough free storage are both available. It then presents a start strobe with the frame length, followed by exactly that many byte beats. Before it begins storing, the block checks the descriptor at the current ring position. If that descriptor is still owned by the host (its EMPTY bit is clear), the frame is swallowed without any effect.

When a frame is accepted, the block stores it padded with zeros to a whole number of 32-bit words. It writes the true length and a host-visible pointer (a fixed base plus the buffer offset where the frame starts) into the descriptor, clears the EMPTY bit, moves to the next descriptor, bumps the received-frame count and pulses the receive-end interrupt. The host drains the data with word reads that advance a read pointer, releases frames with a decrement strobe, re-arms descriptors, can reset the buffer state and can select a byte-reversed read view.

Top module: `rx_pkt_buf`

## Requirements
- R1: The buffer holds 16384 bytes; write and read pointers are byte offsets that wrap modulo 16384, so a frame may straddle the end of the buffer and continue at offset 0.
- R2: `can_accept_o` is low whenever the received-frame count equals the number of descriptors (64).
- R3: `can_accept_o` is low whenever free space is below 1514 bytes. Free space is 16384 minus ((write pointer − read pointer) mod 16384), and a result of 0 counts as 16384.
- R4: Byte k of an accepted frame is stored in bits [8*(k mod 4)+7 : 8*(k mod 4)] of the word at (start offset + k) rounded down to a multiple of 4. Unused lanes of the last word are zero, and the write pointer advances by the length rounded up to a multiple of 4.
- R5: A frame is discarded (no storage write, pointer, count, descriptor or interrupt change) when the current descriptor's EMPTY bit is 0, when `can_accept_o` is low at the start strobe, or when its length is 0.
- R6: On acceptance, the descriptor at the current ring index gets the unrounded length, the pointer 0x4000 + start offset, and EMPTY = 0. The ring index then increments, wrapping from 63 to 0.
- R7: In the cycle after the clock edge that takes the last byte of an accepted frame, the count has risen by one and `irq_o` is high for exactly one cycle.
- R8: A read strobe returns the word at the read pointer on `rd_data_o` with `rd_valid_o` high in the next cycle, and advances the read pointer by 4 modulo 16384.
- R9: With swap mode set (written through `swap_we_i`/`swap_i`), read data comes out with its four bytes reversed; otherwise bytes are unchanged.
- R10: A reset command zeroes the ring index, write pointer, read pointer and frame count, and abandons a frame in progress; `buf_size_o` reads 16384.
- R11: A decrement strobe lowers the count by one, has no effect at zero, and cancels against a simultaneous frame completion so the count is unchanged.
- R12: After `rst_ni` every descriptor has EMPTY = 1; `arm_i` sets EMPTY of the descriptor chosen by `desc_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_start_i | input | 1 | Frame start strobe with length |
| frm_len_i | input | 11 | Frame length in bytes |
| frm_valid_i | input | 1 | Frame byte beat valid |
| frm_byte_i | input | 8 | Frame byte |
| can_accept_o | output | 1 | A frame would be admitted |
| host_rd_i | input | 1 | Read one data word |
| rd_data_o | output | 32 | Read data word |
| rd_valid_o | output | 1 | Read data valid |
| host_dec_i | input | 1 | Release one frame from the count |
| host_reset_i | input | 1 | Reset buffer pointers, index and count |
| swap_we_i | input | 1 | Write swap mode |
| swap_i | input | 1 | New swap mode value |
| swap_o | output | 1 | Current swap mode |
| arm_i | input | 1 | Set EMPTY of selected descriptor |
| desc_sel_i | input | 6 | Descriptor select for view and arm |
| desc_len_o | output | 11 | Selected descriptor length |
| desc_ptr_o | output | 16 | Selected descriptor pointer |
| desc_empty_o | output | 1 | Selected descriptor EMPTY bit |
| frame_cnt_o | output | 7 | Received-frame count |
| rd_ptr_o | output | 14 | Read pointer |
| wr_ptr_o | output | 14 | Write pointer |
| buf_size_o | output | 15 | Buffer size |
| irq_o | output | 1 | Receive-end interrupt pulse |

## Verification
Results fall into two groups. Descriptor fields, count, write pointer and `irq_o` all settle at the clock edge that takes a frame's last byte. Read data, `rd_valid_o` and the advanced read pointer settle at the edge that samples the read strobe. The bench drives every input one time unit after a rising edge and samples the outputs at that same point after the following edge, so each check sees exactly one register stage. The comparisons use a word-level model of the buffer, the descriptors and the count that is updated from the requirements. `irq_o` is checked again one edge later to confirm it lasts a single cycle.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_DROP} rx_state_e;

  function automatic logic [31:0] byte_rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/rxb_space.sv
module rxb_space #(
  parameter int BUF_BYTES = 16384,
  parameter int NUM_DESC  = 64,
  parameter int MAX_FRAME = 1514
) (
  input  logic [$clog2(BUF_BYTES)-1:0]  wr_ptr_i,
  input  logic [$clog2(BUF_BYTES)-1:0]  rd_ptr_i,
  input  logic [$clog2(NUM_DESC+1)-1:0] cnt_i,
  output logic                          can_accept_o
);
  localparam int PTR_W = $clog2(BUF_BYTES);
  localparam int CNT_W = $clog2(NUM_DESC+1);

  logic [PTR_W-1:0] used;
  logic [PTR_W:0]   raw_free, free_b;

  assign used     = wr_ptr_i - rd_ptr_i;
  assign raw_free = (PTR_W+1)'(BUF_BYTES) - {1'b0, used};
  assign free_b   = (raw_free == '0) ? (PTR_W+1)'(BUF_BYTES) : raw_free;

  assign can_accept_o = (cnt_i != CNT_W'(NUM_DESC)) &&
                        (free_b >= (PTR_W+1)'(MAX_FRAME));
endmodule

// File: rtl/rxb_desc_ring.sv
module rxb_desc_ring #(
  parameter int NUM_DESC = 64,
  parameter int LEN_W    = 11,
  parameter int DPTR_W   = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fill_en_i,
  input  logic [$clog2(NUM_DESC)-1:0] fill_idx_i,
  input  logic [LEN_W-1:0]            fill_len_i,
  input  logic [DPTR_W-1:0]           fill_ptr_i,
  input  logic                        arm_en_i,
  input  logic [$clog2(NUM_DESC)-1:0] arm_idx_i,
  input  logic [$clog2(NUM_DESC)-1:0] cur_idx_i,
  output logic                        cur_empty_o,
  input  logic [$clog2(NUM_DESC)-1:0] sel_idx_i,
  output logic [LEN_W-1:0]            sel_len_o,
  output logic [DPTR_W-1:0]           sel_ptr_o,
  output logic                        sel_empty_o
);
  localparam int IDX_W = $clog2(NUM_DESC);

  logic [LEN_W-1:0]  len_a [NUM_DESC];
  logic [DPTR_W-1:0] ptr_a [NUM_DESC];
  logic [NUM_DESC-1:0] empty_v;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    logic [LEN_W-1:0]  e_len;
    logic [DPTR_W-1:0] e_ptr;
    logic              e_empty;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        e_len   <= '0;
        e_ptr   <= '0;
        e_empty <= 1'b1;
      end else begin
        if (fill_en_i && fill_idx_i == IDX_W'(g)) begin
          e_len   <= fill_len_i;
          e_ptr   <= fill_ptr_i;
          e_empty <= 1'b0;
        end
        // host re-arm wins over a same-cycle fill
        if (arm_en_i && arm_idx_i == IDX_W'(g)) e_empty <= 1'b1;
      end
    end
    assign len_a[g]   = e_len;
    assign ptr_a[g]   = e_ptr;
    assign empty_v[g] = e_empty;
  end

  assign cur_empty_o = empty_v[cur_idx_i];
  assign sel_len_o   = len_a[sel_idx_i];
  assign sel_ptr_o   = ptr_a[sel_idx_i];
  assign sel_empty_o = empty_v[sel_idx_i];

  // R5: a fill only lands on a slot the host released
  assert_fill_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |-> empty_v[fill_idx_i]);
  // R6: a fill without re-arm leaves the slot owned by the host
  assert_fill_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !(arm_en_i && arm_idx_i == fill_idx_i)) |=> !empty_v[$past(fill_idx_i)]);
endmodule

// File: rtl/rxb_buf_mem.sv
module rxb_buf_mem #(
  parameter int WORDS = 4096
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(WORDS)-1:0] waddr_i,
  input  logic [31:0]              wdata_i,
  input  logic                     re_i,
  input  logic [$clog2(WORDS)-1:0] raddr_i,
  output logic [31:0]              rdata_o
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/rx_pkt_buf.sv
module rx_pkt_buf
  import rxb_pkg::*;
#(
  parameter int BUF_BYTES = 16384,
  parameter int NUM_DESC  = 64,
  parameter int MAX_FRAME = 1514,
  parameter int LEN_W     = 11,
  parameter int DPTR_W    = 16,
  parameter int DESC_BASE = 16'h4000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          frm_start_i,
  input  logic [LEN_W-1:0]              frm_len_i,
  input  logic                          frm_valid_i,
  input  logic [7:0]                    frm_byte_i,
  output logic                          can_accept_o,
  input  logic                          host_rd_i,
  output logic [31:0]                   rd_data_o,
  output logic                          rd_valid_o,
  input  logic                          host_dec_i,
  input  logic                          host_reset_i,
  input  logic                          swap_we_i,
  input  logic                          swap_i,
  output logic                          swap_o,
  input  logic                          arm_i,
  input  logic [$clog2(NUM_DESC)-1:0]   desc_sel_i,
  output logic [LEN_W-1:0]              desc_len_o,
  output logic [DPTR_W-1:0]             desc_ptr_o,
  output logic                          desc_empty_o,
  output logic [$clog2(NUM_DESC+1)-1:0] frame_cnt_o,
  output logic [$clog2(BUF_BYTES)-1:0]  rd_ptr_o,
  output logic [$clog2(BUF_BYTES)-1:0]  wr_ptr_o,
  output logic [$clog2(BUF_BYTES):0]    buf_size_o,
  output logic                          irq_o
);
  localparam int PTR_W = $clog2(BUF_BYTES);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int IDX_W = $clog2(NUM_DESC);
  localparam int CNT_W = $clog2(NUM_DESC+1);

  rx_state_e        st_q;
  logic [PTR_W-1:0] wr_q, rd_q, start_q;
  logic [LEN_W-1:0] rem_q, len_q;
  logic [1:0]       lane_q;
  logic [31:0]      acc_q, word_in, mem_q;
  logic [IDX_W-1:0] didx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             swap_q, irq_q, rvalid_q, rswap_q;
  logic             can_acc, cur_empty, last_byte, wr_word, fin, start_ok, dec_eff;

  rxb_space #(.BUF_BYTES(BUF_BYTES), .NUM_DESC(NUM_DESC), .MAX_FRAME(MAX_FRAME)) u_space (
    .wr_ptr_i(wr_q), .rd_ptr_i(rd_q), .cnt_i(cnt_q), .can_accept_o(can_acc)
  );

  assign last_byte = frm_valid_i && (rem_q == LEN_W'(1));
  assign word_in   = acc_q | (32'(frm_byte_i) << {lane_q, 3'b000});
  assign wr_word   = (st_q == ST_RECV) && frm_valid_i && ((lane_q == 2'd3) || last_byte)
                     && !host_reset_i;
  assign fin       = (st_q == ST_RECV) && last_byte && !host_reset_i;
  assign start_ok  = can_acc && cur_empty;
  assign dec_eff   = host_dec_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      wr_q    <= '0;
      rd_q    <= '0;
      start_q <= '0;
      rem_q   <= '0;
      len_q   <= '0;
      lane_q  <= '0;
      acc_q   <= '0;
      didx_q  <= '0;
    end else if (host_reset_i) begin
      st_q   <= ST_IDLE;
      wr_q   <= '0;
      rd_q   <= '0;
      lane_q <= '0;
      acc_q  <= '0;
      didx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (frm_start_i && frm_len_i != '0) begin
          rem_q   <= frm_len_i;
          len_q   <= frm_len_i;
          start_q <= wr_q;
          lane_q  <= '0;
          acc_q   <= '0;
          st_q    <= start_ok ? ST_RECV : ST_DROP;
        end
        ST_RECV: if (frm_valid_i) begin
          rem_q  <= rem_q - LEN_W'(1);
          lane_q <= lane_q + 2'd1;
          acc_q  <= wr_word ? '0 : word_in;
          if (wr_word) wr_q <= wr_q + PTR_W'(4);
          if (last_byte) begin
            st_q   <= ST_IDLE;
            didx_q <= (didx_q == IDX_W'(NUM_DESC-1)) ? '0 : didx_q + IDX_W'(1);
          end
        end
        ST_DROP: if (frm_valid_i) begin
          rem_q <= rem_q - LEN_W'(1);
          if (last_byte) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (host_rd_i) rd_q <= rd_q + PTR_W'(4);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (host_reset_i)      cnt_q <= '0;
    else if (fin && !dec_eff)   cnt_q <= cnt_q + CNT_W'(1);
    else if (dec_eff && !fin)   cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swap_q   <= 1'b0;
      irq_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rswap_q  <= 1'b0;
    end else begin
      if (swap_we_i) swap_q <= swap_i;
      irq_q    <= fin;
      rvalid_q <= host_rd_i && !host_reset_i;
      rswap_q  <= swap_q;
    end
  end

  rxb_buf_mem #(.WORDS(WORDS)) u_mem (
    .clk_i(clk_i), .we_i(wr_word), .waddr_i(wr_q[PTR_W-1:2]), .wdata_i(word_in),
    .re_i(host_rd_i), .raddr_i(rd_q[PTR_W-1:2]), .rdata_o(mem_q)
  );

  rxb_desc_ring #(.NUM_DESC(NUM_DESC), .LEN_W(LEN_W), .DPTR_W(DPTR_W)) u_ring (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fill_en_i(fin), .fill_idx_i(didx_q), .fill_len_i(len_q),
    .fill_ptr_i(DPTR_W'(DESC_BASE) + DPTR_W'(start_q)),
    .arm_en_i(arm_i), .arm_idx_i(desc_sel_i),
    .cur_idx_i(didx_q), .cur_empty_o(cur_empty),
    .sel_idx_i(desc_sel_i), .sel_len_o(desc_len_o), .sel_ptr_o(desc_ptr_o),
    .sel_empty_o(desc_empty_o)
  );

  assign can_accept_o = can_acc;
  assign rd_data_o    = rswap_q ? byte_rev(mem_q) : mem_q;
  assign rd_valid_o   = rvalid_q;
  assign swap_o       = swap_q;
  assign frame_cnt_o  = cnt_q;
  assign rd_ptr_o     = rd_q;
  assign wr_ptr_o     = wr_q;
  assign buf_size_o   = (PTR_W+1)'(BUF_BYTES);
  assign irq_o        = irq_q;

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_DESC));
  assert_full_refuse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    can_acc |-> (cnt_q != CNT_W'(NUM_DESC)));
  assert_irq_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !host_dec_i) |=> (irq_o && cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_rd_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !host_reset_i) |=> (rd_q == $past(rd_q) + PTR_W'(4)) && rd_valid_o);
  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_reset_i |=> (wr_q == '0 && rd_q == '0 && cnt_q == '0 && didx_q == '0));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && host_dec_i) |=> $stable(cnt_q));
  assert_no_write_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DROP) |=> $stable(wr_q) || $past(host_reset_i));
endmodule

// File: tb/rx_pkt_buf_bench.sv
`timescale 1ns/1ps
module rx_pkt_buf_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        frm_start_i = 0, frm_valid_i = 0, host_rd_i = 0, host_dec_i = 0;
  logic        host_reset_i = 0, swap_we_i = 0, swap_i = 0, arm_i = 0;
  logic [10:0] frm_len_i = '0;
  logic [7:0]  frm_byte_i = '0;
  logic [5:0]  desc_sel_i = '0;
  logic        can_accept_o, rd_valid_o, swap_o, desc_empty_o, irq_o;
  logic [31:0] rd_data_o;
  logic [10:0] desc_len_o;
  logic [15:0] desc_ptr_o;
  logic [6:0]  frame_cnt_o;
  logic [13:0] rd_ptr_o, wr_ptr_o;
  logic [14:0] buf_size_o;

  rx_pkt_buf u_rx_pkt_buf (
    .clk_i(clk), .rst_ni(rst_n), .frm_start_i(frm_start_i), .frm_len_i(frm_len_i),
    .frm_valid_i(frm_valid_i), .frm_byte_i(frm_byte_i), .can_accept_o(can_accept_o),
    .host_rd_i(host_rd_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .host_dec_i(host_dec_i), .host_reset_i(host_reset_i), .swap_we_i(swap_we_i),
    .swap_i(swap_i), .swap_o(swap_o), .arm_i(arm_i), .desc_sel_i(desc_sel_i),
    .desc_len_o(desc_len_o), .desc_ptr_o(desc_ptr_o), .desc_empty_o(desc_empty_o),
    .frame_cnt_o(frame_cnt_o), .rd_ptr_o(rd_ptr_o), .wr_ptr_o(wr_ptr_o),
    .buf_size_o(buf_size_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] mwords [4096];
  int m_wr = 0, m_rd = 0, m_cnt = 0, m_didx = 0;
  bit m_swap = 0;
  bit m_empty [64];
  int m_len [64];
  int m_ptr [64];

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int mfree();
    int f;
    f = 16384 - ((m_wr - m_rd) & 16383);
    if (f == 0) f = 16384;
    return f;
  endfunction

  function automatic logic [31:0] exp_word(input int p);
    logic [31:0] w;
    w = mwords[(p >> 2) & 4095];
    if (m_swap) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
    return w;
  endfunction

  task automatic send_frame(input int len, input bit dec_end);
    bit acc;
    int idx0, wr0, rnd, p;
    logic [7:0] b;
    if (m_cnt == 64) chk("R2 can_accept at full count", 32'(can_accept_o), 32'(0));
    else chk("R3 can_accept vs free space", 32'(can_accept_o), 32'(mfree() >= 1514));
    acc  = (len != 0) && (m_cnt != 64) && (mfree() >= 1514) && m_empty[m_didx];
    idx0 = m_didx;
    wr0  = m_wr;
    rnd  = (len + 3) & ~3;
    frm_start_i = 1; frm_len_i = 11'(len);
    tick();
    frm_start_i = 0;
    for (int i = 0; i < len; i++) begin
      b = 8'($urandom);
      frm_valid_i = 1; frm_byte_i = b;
      if (acc) begin
        p = (wr0 + i) & 16383;
        mwords[p >> 2][8*(p % 4) +: 8] = b;
      end
      if (i == len - 1) host_dec_i = dec_end;
      tick();
      frm_valid_i = 0; host_dec_i = 0;
    end
    if (acc) begin
      for (int i = len; i < rnd; i++) begin
        p = (wr0 + i) & 16383;
        mwords[p >> 2][8*(p % 4) +: 8] = 8'h00;
      end
      m_len[idx0] = len; m_ptr[idx0] = 16'h4000 + wr0; m_empty[idx0] = 0;
      m_wr = (m_wr + rnd) & 16383;
      m_didx = (m_didx + 1) % 64;
    end
    if (acc && !(dec_end && m_cnt != 0)) m_cnt++;
    else if (!acc && dec_end && m_cnt != 0) m_cnt--;
    chk("R7 irq after last byte", 32'(irq_o), 32'(acc));
    chk("R11 count after frame", 32'(frame_cnt_o), 32'(m_cnt));
    chk(acc ? "R4 write pointer advance" : "R5 write pointer kept", 32'(wr_ptr_o), 32'(m_wr));
    if (acc) begin
      desc_sel_i = 6'(idx0);
      #1;
      chk("R6 descriptor length", 32'(desc_len_o), 32'(len));
      chk("R6 descriptor pointer", 32'(desc_ptr_o), 32'(m_ptr[idx0]));
      chk("R6 descriptor empty cleared", 32'(desc_empty_o), 32'(0));
    end
    tick();
    chk("R7 irq single cycle", 32'(irq_o), 32'(0));
  endtask

  task automatic host_read(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      host_rd_i = 1;
      tick();
      chk(tag, rd_data_o, exp_word(m_rd));
      n_chk++;
      if (rd_valid_o !== 1'b1) begin n_err++; $display("FAIL R8 rd_valid act=%0b exp=1", rd_valid_o); end
      m_rd = (m_rd + 4) & 16383;
    end
    host_rd_i = 0;
    chk("R8 read pointer", 32'(rd_ptr_o), 32'(m_rd));
  endtask

  task automatic dec_once();
    host_dec_i = 1;
    tick();
    host_dec_i = 0;
    if (m_cnt != 0) m_cnt--;
    chk("R11 decrement", 32'(frame_cnt_o), 32'(m_cnt));
  endtask

  task automatic reset_cmd();
    host_reset_i = 1;
    tick();
    host_reset_i = 0;
    m_wr = 0; m_rd = 0; m_cnt = 0; m_didx = 0;
    chk("R10 write pointer cleared", 32'(wr_ptr_o), 32'(0));
    chk("R10 read pointer cleared", 32'(rd_ptr_o), 32'(0));
    chk("R10 count cleared", 32'(frame_cnt_o), 32'(0));
    chk("R10 size", 32'(buf_size_o), 32'(16384));
  endtask

  task automatic arm_all();
    for (int i = 0; i < 64; i++) begin
      desc_sel_i = 6'(i); arm_i = 1;
      tick();
      arm_i = 0;
      m_empty[i] = 1;
    end
    desc_sel_i = 6'd5;
    #1;
    chk("R12 arm sets empty", 32'(desc_empty_o), 32'(1));
  endtask

  task automatic set_swap(input bit v);
    swap_we_i = 1; swap_i = v;
    tick();
    swap_we_i = 0;
    m_swap = v;
    chk("R9 swap mode", 32'(swap_o), 32'(v));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) m_empty[i] = 1;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // reset state
    chk("R10 reset size", 32'(buf_size_o), 32'(16384));
    chk("R2 reset can_accept", 32'(can_accept_o), 32'(1));
    chk("R7 reset irq", 32'(irq_o), 32'(0));
    chk("R8 reset rd_valid", 32'(rd_valid_o), 32'(0));
    desc_sel_i = 6'd0;
    #1;
    chk("R12 reset empty", 32'(desc_empty_o), 32'(1));

    // random frames, read back straight and swapped
    for (int f = 0; f < 20; f++) send_frame(1 + int'($urandom_range(0, 63)), 1'b0);
    host_read(((m_wr - m_rd) & 16383) / 8, "R4 packed word");
    set_swap(1);
    host_read(((m_wr - m_rd) & 16383) / 4, "R9 swapped word");
    set_swap(0);
    for (int f = 0; f < 20; f++) dec_once();
    dec_once();  // R11 at zero

    // occupied descriptor and zero length are dropped
    reset_cmd();
    send_frame(9, 1'b0);   // R5: descriptor 0 still filled
    send_frame(0, 1'b0);   // R5: zero length
    arm_all();

    // fill to 64 frames
    for (int f = 0; f < 64; f++) send_frame(1 + int'($urandom_range(0, 7)), 1'b0);
    chk("R2 count full", 32'(frame_cnt_o), 32'(64));
    chk("R6 index wrapped to 0", 32'(m_didx), 32'(0));
    send_frame(5, 1'b0);   // refused at full count
    dec_once();
    chk("R2 accept after release", 32'(can_accept_o), 32'(1));
    desc_sel_i = 6'd0; arm_i = 1; tick(); arm_i = 0; m_empty[0] = 1;
    send_frame(6, 1'b1);   // R11 simultaneous inc and dec
    chk("R11 hold count", 32'(frame_cnt_o), 32'(63));

    // space limit and wrap
    reset_cmd();
    arm_all();
    for (int f = 0; f < 10; f++) send_frame(1514, 1'b0);
    chk("R3 refuse low space", 32'(can_accept_o), 32'(0));
    send_frame(1514, 1'b0);
    host_read(379, "R4 first frame data");
    chk("R3 accept after drain", 32'(can_accept_o), 32'(1));
    send_frame(1514, 1'b0);
    chk("R1 write pointer wrapped", 32'(wr_ptr_o), 32'(292));
    host_read(((m_wr - m_rd) & 16383) / 4, "R1 wrapped data");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule